// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Delayed Register Updates

This block keeps a 32-bit count of elapsed seconds for a processor that reaches it through a simple memory-mapped register port. A one-hertz enable pulse, synchronous to the fast bus clock, advances the count. Software can preload the count, program an alarm value, enable or disable the single interrupt line, and acknowledge the alarm event.

All four of these control writes take effect in the slow time domain. None of them reaches the counting logic at once: a write is held in a pending slot and applied on the second one-second tick after it. This models the two-stage crossing into the slow clock. While a write is pending, a dedicated busy bit in the status register stays set, so software can poll for completion. Reads of the load, alarm and mask registers return the last value written, even before it has been applied.

Top module: `rtc_sync_top`

## Requirements
- R1: After reset the time register reads 0, the status register reads 0, the masked interrupt register reads 0, the load register reads 0, the alarm register reads 0xFFFFFFFF, and `irq_o` is low.
- R2: The time register at offset 0x00 advances by exactly one on each cycle where `tick_i` is high, holds its value on every other cycle, and ignores bus writes.
- R3: A write to the load register at offset 0x08 reads back at once. The time register takes the written value on the second tick after the write; the first tick still counts up by one.
- R4: Status register offset 0x14 holds one busy bit per operation: bit 0 load, bit 1 alarm, bit 2 acknowledge, bit 3 mask. A bit is set in the cycle after its write and is cleared by the second tick after that write.
- R5: A write to the alarm register at offset 0x04 reads back at once and becomes the compare value on the second tick after the write.
- R6: When a tick advances the count from a value equal to the applied alarm value, the alarm event is raised. The event stays raised until it is acknowledged.
- R7: The mask register at offset 0x0C is one bit (bit 0) and is applied on the second tick after its write. `irq_o` and bit 0 of the masked interrupt register at offset 0x10 are high exactly when the alarm event is raised and the applied mask is 1.
- R8: Writing 0x10 with bit 0 set clears the alarm event on the second tick after the write. Writing it with bit 0 clear sets the acknowledge busy bit but leaves the event raised.
- R9: A write to a register whose busy bit is still set replaces the pending value without restarting the wait. The newer value is applied on the tick that would have applied the older one.
- R10: Reads of offsets with no register (for example 0x18 and 0x1C) return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second, synchronous to clk |
| sel_i | input | 1 | Register access select |
| wen_i | input | 1 | Write when high, read when low |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, zero when not selected |
| irq_o | output | 1 | Masked alarm interrupt |

## Verification
On every cycle, the assertions check the following: the count holds between ticks and steps by one on a plain tick; a busy bit rises only after its write and falls only on a tick; and the alarm event and the interrupt line change only on a tick or on an applied acknowledge. Other behaviour can only be seen in the bench's scenarios. This covers the exact two-tick latency of each operation and the readback of values not yet applied. It also covers the alarm firing exactly one tick after the count reaches the compare value, a zero-valued acknowledge leaving the event in place, and a rewrite during the wait being applied without delay.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_CH = 4;
  // channel index equals its busy bit position in the status register
  localparam int CH_LOAD  = 0;
  localparam int CH_ALARM = 1;
  localparam int CH_ACK   = 2;
  localparam int CH_MASK  = 3;

  localparam logic [7:0] OFF_TIME   = 8'h00;
  localparam logic [7:0] OFF_ALARM  = 8'h04;
  localparam logic [7:0] OFF_LOAD   = 8'h08;
  localparam logic [7:0] OFF_MASK   = 8'h0C;
  localparam logic [7:0] OFF_MIS    = 8'h10;
  localparam logic [7:0] OFF_STATUS = 8'h14;

  function automatic logic [7:0] chan_offset(input int k);
    case (k)
      CH_LOAD:  return OFF_LOAD;
      CH_ALARM: return OFF_ALARM;
      CH_ACK:   return OFF_MIS;
      default:  return OFF_MASK;
    endcase
  endfunction

  function automatic int chan_width(input int k, input int dw);
    return (k == CH_LOAD || k == CH_ALARM) ? dw : 1;
  endfunction

  function automatic bit chan_rst_ones(input int k);
    return k == CH_ALARM;
  endfunction

  function automatic logic [31:0] next_count(input logic [31:0] cnt,
                                             input logic load_now,
                                             input logic [31:0] load_val);
    return load_now ? load_val : cnt + 32'd1;
  endfunction

  function automatic logic alarm_crossed(input logic [31:0] cnt,
                                         input logic [31:0] alarm);
    return cnt == alarm;
  endfunction
endpackage

// File: rtl/rtc_xfer_slot.sv
module rtc_xfer_slot #(
  parameter int W          = 32,
  parameter int SYNC_TICKS = 2,
  parameter bit RST_ONES   = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic         apply_o,
  output logic [W-1:0] val_o
);
  localparam int SW = $clog2(SYNC_TICKS + 1);
  localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : '0;
  localparam logic [SW-1:0] LAST = SW'(SYNC_TICKS - 1);

  logic          busy_q;
  logic [SW-1:0] stage_q;
  logic [W-1:0]  val_q;

  assign apply_o = tick_i && busy_q && (stage_q == LAST) && !wr_i;
  assign busy_o  = busy_q;
  assign val_o   = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      stage_q <= '0;
      val_q   <= RST_VAL;
    end else if (wr_i) begin
      val_q  <= wdata_i;
      busy_q <= 1'b1;
      if (!busy_q) stage_q <= '0;
    end else if (tick_i && busy_q) begin
      if (stage_q == LAST) begin
        busy_q  <= 1'b0;
        stage_q <= '0;
      end else begin
        stage_q <= stage_q + SW'(1);
      end
    end
  end

  assert_busy_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> busy_o);
  assert_busy_falls_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(tick_i));
  assert_apply_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    apply_o |=> !busy_o);
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          load_apply_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          alarm_apply_i,
  input  logic [DW-1:0] alarm_val_i,
  input  logic          ack_apply_i,
  input  logic          ack_val_i,
  input  logic          mask_apply_i,
  input  logic          mask_val_i,
  output logic [DW-1:0] time_o,
  output logic          raw_o,
  output logic          irq_o
);
  import rtc_pkg::*;

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] alarm_q;
  logic          mask_q;
  logic          raw_q;
  logic          hit;

  assign hit = tick_i && alarm_crossed(32'(cnt_q), 32'(alarm_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= '1;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      if (tick_i)
        cnt_q <= DW'(next_count(32'(cnt_q), load_apply_i, 32'(load_val_i)));
      if (alarm_apply_i) alarm_q <= alarm_val_i;
      if (mask_apply_i)  mask_q  <= mask_val_i;
      if (hit)                           raw_q <= 1'b1;
      else if (ack_apply_i && ack_val_i) raw_q <= 1'b0;
    end
  end

  assign time_o = cnt_q;
  assign raw_o  = raw_q;
  assign irq_o  = raw_q & mask_q;

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_apply_i) |=> cnt_q == $past(cnt_q) + DW'(1));
  assert_event_rises_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(tick_i));
  assert_event_clears_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(raw_q) |-> $past(ack_apply_i));
endmodule

// File: rtl/rtc_sync_top.sv
module rtc_sync_top #(
  parameter int DW         = 32,
  parameter int ADDR_W     = 5,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  import rtc_pkg::*;

  logic [7:0]          addr8;
  logic [NUM_CH-1:0]   wr_ch;
  logic [NUM_CH-1:0]   busy_vec;
  logic [NUM_CH-1:0]   apply_vec;
  logic [DW-1:0]       val_all [NUM_CH];
  logic [DW-1:0]       time_w;
  logic                raw_w;

  assign addr8 = 8'(addr_i);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int CW = chan_width(k, DW);
    logic [CW-1:0] v;
    assign wr_ch[k] = sel_i && wen_i && (addr8 == chan_offset(k));
    rtc_xfer_slot #(.W(CW), .SYNC_TICKS(SYNC_TICKS), .RST_ONES(chan_rst_ones(k))) u_slot (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_ch[k]),
      .wdata_i(wdata_i[CW-1:0]), .busy_o(busy_vec[k]), .apply_o(apply_vec[k]),
      .val_o(v)
    );
    if (CW < DW) begin : g_pad
      assign val_all[k] = {{(DW-CW){1'b0}}, v};
    end else begin : g_full
      assign val_all[k] = v;
    end
  end

  rtc_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .load_apply_i(apply_vec[CH_LOAD]),   .load_val_i(val_all[CH_LOAD]),
    .alarm_apply_i(apply_vec[CH_ALARM]), .alarm_val_i(val_all[CH_ALARM]),
    .ack_apply_i(apply_vec[CH_ACK]),     .ack_val_i(val_all[CH_ACK][0]),
    .mask_apply_i(apply_vec[CH_MASK]),   .mask_val_i(val_all[CH_MASK][0]),
    .time_o(time_w), .raw_o(raw_w), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (addr8)
        OFF_TIME:   rdata_o = time_w;
        OFF_ALARM:  rdata_o = val_all[CH_ALARM];
        OFF_LOAD:   rdata_o = val_all[CH_LOAD];
        OFF_MASK:   rdata_o = val_all[CH_MASK];
        OFF_MIS:    rdata_o = DW'(irq_o);
        OFF_STATUS: rdata_o = DW'(busy_vec);
        default:    rdata_o = '0;
      endcase
    end
  end

  assert_load_busy_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_vec[CH_LOAD]) |-> $past(sel_i && wen_i));
  assert_irq_moves_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(tick_i));
  assert_irq_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> raw_w);
endmodule

// File: tb/sim_rtc_sync_top.sv
`timescale 1ns/100ps
module sim_rtc_sync_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sel = 1'b0;
  logic        wen = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  rtc_sync_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sel_i(sel), .wen_i(wen),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [4:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  item_t it;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;

  // monitor: compares the oldest expected item against the outputs
  always @(negedge clk) begin
    if (q.size() != 0) begin
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s addr=0x%0h actual=0x%0h expected=0x%0h", it.tag, it.a, act, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    sel = 1'b1; wen = 1'b0; addr = a;
    q.push_back('{1'b0, a, e, tag});
    @(negedge clk);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    @(posedge clk); #1;
    sel = 1'b0; wen = 1'b0;
    q.push_back('{1'b1, 5'd0, {31'b0, e}, tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    sel = 1'b1; wen = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wen = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sel = 1'b0; wen = 1'b0; tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
      repeat (3) @(posedge clk);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_rd(5'h00, 32'd0, "R1 time");
    expect_rd(5'h14, 32'd0, "R1 status");
    expect_rd(5'h10, 32'd0, "R1 masked status");
    expect_rd(5'h08, 32'd0, "R1 load");
    expect_rd(5'h04, 32'hFFFF_FFFF, "R1 alarm");
    expect_irq(1'b0, "R1 irq");

    // R2 counting, hold between ticks, write ignored
    ticks(3);
    expect_rd(5'h00, 32'd3, "R2 three ticks");
    wr(5'h00, 32'd55);
    repeat (5) @(posedge clk);
    expect_rd(5'h00, 32'd3, "R2 write ignored and held");

    // R3 / R4 load latency and busy bit 0
    wr(5'h08, 32'd1000);
    expect_rd(5'h08, 32'd1000, "R3 load readback");
    expect_rd(5'h14, 32'd1, "R4 load busy");
    ticks(1);
    expect_rd(5'h00, 32'd4, "R3 first tick still counts");
    expect_rd(5'h14, 32'd1, "R4 load busy after one tick");
    ticks(1);
    expect_rd(5'h00, 32'd1000, "R3 load applied");
    expect_rd(5'h14, 32'd0, "R4 load busy cleared");
    ticks(1);
    expect_rd(5'h00, 32'd1001, "R2 count after load");

    // R5 / R6 alarm
    wr(5'h04, 32'd1003);
    expect_rd(5'h04, 32'd1003, "R5 alarm readback");
    expect_rd(5'h14, 32'd2, "R4 alarm busy");
    ticks(2);
    expect_rd(5'h00, 32'd1003, "R5 time at alarm value");
    expect_rd(5'h14, 32'd0, "R4 alarm busy cleared");
    ticks(1);
    expect_rd(5'h10, 32'd0, "R7 masked event not visible");
    expect_irq(1'b0, "R7 irq masked");

    // R7 mask
    wr(5'h0C, 32'd1);
    expect_rd(5'h14, 32'd8, "R4 mask busy");
    ticks(1);
    expect_irq(1'b0, "R7 mask not yet applied");
    ticks(1);
    expect_irq(1'b1, "R6 event sticky, irq asserted");
    expect_rd(5'h10, 32'd1, "R7 masked status");
    expect_rd(5'h0C, 32'd1, "R7 mask readback");

    // R8 acknowledge
    wr(5'h10, 32'd0);
    expect_rd(5'h14, 32'd4, "R4 ack busy");
    ticks(2);
    expect_irq(1'b1, "R8 zero ack keeps event");
    wr(5'h10, 32'd1);
    expect_rd(5'h14, 32'd4, "R8 ack busy");
    ticks(1);
    expect_irq(1'b1, "R8 ack pending");
    ticks(1);
    expect_irq(1'b0, "R8 ack applied");
    expect_rd(5'h10, 32'd0, "R8 masked status cleared");
    expect_rd(5'h00, 32'd1010, "R2 count check");

    // R9 rewrite while busy
    wr(5'h08, 32'd5000);
    ticks(1);
    expect_rd(5'h14, 32'd1, "R9 still busy");
    wr(5'h08, 32'd7000);
    expect_rd(5'h08, 32'd7000, "R9 replaced readback");
    ticks(1);
    expect_rd(5'h00, 32'd7000, "R9 newer value applied on original tick");
    expect_rd(5'h14, 32'd0, "R9 busy cleared");
    ticks(1);
    expect_rd(5'h00, 32'd7001, "R2 count after rewrite");

    // R10 unmapped
    expect_rd(5'h18, 32'd0, "R10 unmapped 0x18");
    expect_rd(5'h1C, 32'd0, "R10 unmapped 0x1C");

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule